// File: doc/BRIEF.md
# Commutative Line Merge Sequencer

This block folds a core's privately updated cache lines back into the shared cache. Each privatized line has three copies: the value as first read (source copy), the value after local updates (updated copy), and the shared-cache value at merge time (memory copy). The sequencer combines them with a merge kernel, so that the shared copy reflects the core's local updates.

A full-merge command snapshots the valid source entries and handles them one at a time, lowest index first. An evict command does the same for one named entry. For a dirty line the sequencer requests the shared-cache lock and waits for the grant. On the grant edge it loads the source, updated and memory merge registers. It then steps the kernel through the line one 32-bit word per cycle and offers the merged memory line on a valid/ready writeback stream. Once the writeback is accepted it pulses the entry-clear strobe, which both invalidates the source entry and clears the line's commutative bit. It drops the lock on the following cycle. A clean line takes no lock: it is cleared at once, with no writeback.

The kernel for a line is chosen indirectly. The line's 2-bit merge type indexes a 4-slot function table, and software rewrites the slots with a configuration write. Only one line is ever under lock, so each line's merge is atomic on its own and a group of lines is not.

Top module: `merge_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `busy`, `lock_req`, `wb_valid` and `ent_clr` are all low.
- R2: After reset, table slot s holds kernel code s. A cycle with `cfg_we` high writes `cfg_kind` into slot `cfg_slot`. Entry e's merge type sits at `ent_mtype[2e+1:2e]` and selects the slot whose kernel merges that entry. The slot is read when the entry is picked.
- R3: A one-cycle `cmd_full` pulse taken while idle merges every entry whose `ent_valid` bit was set on that edge, each exactly once, in ascending index order. `line_idx` names the entry being handled.
- R4: A `cmd_evict` pulse taken while idle, with `cmd_full` low, merges only entry `cmd_idx`, and only if that entry is valid. An invalid entry produces no lock, no writeback and no clear.
- R5: For a dirty entry, `lock_req` rises and stays high until the grant. No writeback is offered before the grant. `wb_valid` is only ever high while `lock_req` is high. `ent_clr` pulses for one cycle, under the lock, after the writeback is accepted. `lock_req` falls on the next cycle.
- R6: A clean entry (its `ent_dirty` bit low) gets a single `ent_clr` pulse with `lock_req` low, and no writeback.
- R7: Kernel code 0 (add-delta) computes, per 32-bit lane, memory + (updated − source) modulo 2^32. Lane w occupies bits [32w+31:32w] of every line.
- R8: Kernel code 1 (saturating add-delta) computes the R7 sum per lane. It yields `SAT_LIMIT` when the memory lane is already at or above `SAT_LIMIT`, or when the sum (unsigned) exceeds it.
- R9: Kernel code 2 yields, per lane, memory OR updated.
- R10: Kernel code 3 yields, per lane, the unsigned minimum of memory and updated.
- R11: Writeback follows valid/ready. While `wb_valid` is high and `wb_ready` low, `wb_valid`, `wb_line` and `line_idx` hold. The transfer completes on an edge where both are high.
- R12: `cmd_full` and `cmd_evict` are ignored while `busy` is high: no entry gets an extra visit.
- R13: The kernel walks one word per cycle. `wb_valid` first rises exactly LANES clock edges after the edge that samples `lock_gnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Function table write strobe |
| cfg_slot | input | 2 | Table slot to write |
| cfg_kind | input | 2 | Kernel code for the slot (0 add, 1 saturating add, 2 OR, 3 min) |
| cmd_full | input | 1 | Start a merge of all valid entries |
| cmd_evict | input | 1 | Start a merge of one entry |
| cmd_idx | input | IW | Entry for `cmd_evict` |
| ent_valid | input | NENT | Source entry valid bits |
| ent_dirty | input | NENT | Line dirty bits |
| ent_mtype | input | 2*NENT | Per-entry merge type, 2 bits each |
| line_idx | output | IW | Entry currently handled (lock, read, writeback and clear target) |
| sb_src_line | input | LANES*LW | Source copy of entry `line_idx` |
| l1_upd_line | input | LANES*LW | Updated copy of entry `line_idx` |
| lock_req | output | 1 | Shared-line lock request, held until release |
| lock_gnt | input | 1 | Lock grant; `mem_line` is valid in this cycle |
| mem_line | input | LANES*LW | Shared-cache copy returned with the grant |
| wb_valid | output | 1 | Merged line offered for writeback |
| wb_ready | input | 1 | Writeback accepted |
| wb_line | output | LANES*LW | Merged memory line |
| ent_clr | output | 1 | One-cycle strobe: invalidate entry and clear its commutative bit |
| busy | output | 1 | Sequencer not idle |

## Verification
The assertions assume a well-behaved environment on four points:
- `lock_gnt` arrives only while `lock_req` is high, and only once per request.
- `mem_line`, `sb_src_line` and `l1_upd_line` are valid for `line_idx` in the grant cycle.
- The dirty bits and merge types stay unchanged while `busy` is high.
- `wb_ready` may toggle freely.

The stimulus grants exactly once per request, after a programmable delay, and serves the data from arrays indexed by `line_idx`. It changes the arrays and the table only between commands, and it throttles `wb_ready` in a fixed pattern during the back-pressure phases.

// File: rtl/merge_seq_pkg.sv
package merge_seq_pkg;

  // Kernel codes held in the function table (R7..R10)
  typedef enum logic [1:0] {
    K_ADD = 2'd0,
    K_SAT = 2'd1,
    K_OR  = 2'd2,
    K_MIN = 2'd3
  } kern_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PICK,
    S_LOCK_WAIT,
    S_RUN,
    S_WB,
    S_CLR,
    S_DROP
  } seq_st_e;

endpackage

// File: rtl/merge_ftable.sv
module merge_ftable import merge_seq_pkg::*; #(
  parameter int NSLOT = 4,
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_slot,
  input  kern_e         wr_kind,
  input  logic [SW-1:0] rd_slot,
  output kern_e         rd_kind
);

  kern_e slot_q [NSLOT];

  // R2: identity mapping after reset, rewritten by configuration
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (!rst_n)
        slot_q[i] <= kern_e'(2'(i % 4));
      else if (wr_en && wr_slot == SW'(i))
        slot_q[i] <= wr_kind;
    end
  end

  assign rd_kind = slot_q[rd_slot];

endmodule

// File: rtl/merge_regs.sv
module merge_regs #(
  parameter int LANES = 16,
  parameter int LW    = 32,
  localparam int WW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LINE = LANES * LW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LINE-1:0] ld_src,
  input  logic [LINE-1:0] ld_upd,
  input  logic [LINE-1:0] ld_mem,
  input  logic [WW-1:0]   word_idx,
  output logic [LW-1:0]   rd_src,
  output logic [LW-1:0]   rd_upd,
  output logic [LW-1:0]   rd_mem,
  input  logic            wr_en,
  input  logic [LW-1:0]   wr_data,
  output logic [LINE-1:0] mem_line
);

  logic [LW-1:0] src_q [LANES];
  logic [LW-1:0] upd_q [LANES];
  logic [LW-1:0] mem_q [LANES];

  // Source and updated registers are read-only once filled; memory is read-write
  always_ff @(posedge clk) begin
    for (int w = 0; w < LANES; w++) begin
      if (!rst_n) begin
        src_q[w] <= '0;
        upd_q[w] <= '0;
        mem_q[w] <= '0;
      end else if (load) begin
        src_q[w] <= ld_src[w*LW +: LW];
        upd_q[w] <= ld_upd[w*LW +: LW];
        mem_q[w] <= ld_mem[w*LW +: LW];
      end else if (wr_en && word_idx == WW'(w)) begin
        mem_q[w] <= wr_data;
      end
    end
  end

  assign rd_src = src_q[word_idx];
  assign rd_upd = upd_q[word_idx];
  assign rd_mem = mem_q[word_idx];

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign mem_line[g*LW +: LW] = mem_q[g];
  end

endmodule

// File: rtl/merge_kernel.sv
module merge_kernel import merge_seq_pkg::*; #(
  parameter int LW = 32,
  parameter logic [LW-1:0] SAT_LIMIT = '1
) (
  input  kern_e         kind,
  input  logic [LW-1:0] src_w,
  input  logic [LW-1:0] upd_w,
  input  logic [LW-1:0] mem_w,
  output logic [LW-1:0] res_w
);

  logic [LW-1:0] delta;
  logic [LW-1:0] sum;

  always_comb begin
    delta = upd_w - src_w;
    sum   = mem_w + delta;
    unique case (kind)
      K_ADD: res_w = sum;                                            // R7
      K_SAT: res_w = (mem_w >= SAT_LIMIT || sum > SAT_LIMIT)
                     ? SAT_LIMIT : sum;                              // R8
      K_OR:  res_w = mem_w | upd_w;                                  // R9
      K_MIN: res_w = (upd_w < mem_w) ? upd_w : mem_w;                // R10
      default: res_w = mem_w;
    endcase
  end

endmodule

// File: rtl/merge_seq_ctl.sv
module merge_seq_ctl import merge_seq_pkg::*; #(
  parameter int NENT  = 8,
  parameter int LANES = 16,
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int WW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_full,
  input  logic            cmd_evict,
  input  logic [IW-1:0]   cmd_idx,
  input  logic [NENT-1:0] ent_valid,
  input  logic [NENT-1:0] ent_dirty,
  output logic [IW-1:0]   pick_idx,
  input  kern_e           pick_kind,
  output logic [IW-1:0]   cur_idx,
  output kern_e           cur_kind,
  output logic [WW-1:0]   word_idx,
  input  logic            lock_gnt,
  input  logic            wb_ready,
  output logic            fill,
  output logic            wr_en,
  output logic            lock_req,
  output logic            wb_valid,
  output logic            ent_clr,
  output logic            busy
);

  seq_st_e         st_q;
  logic [NENT-1:0] pend_q;
  logic            pick_found;

  // Lowest pending index wins (R3)
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        pick_found = 1'b1;
        pick_idx   = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      pend_q   <= '0;
      cur_idx  <= '0;
      cur_kind <= K_ADD;
      word_idx <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: begin
          // Commands are only looked at here (R12)
          if (cmd_full) begin
            pend_q <= ent_valid;
            st_q   <= S_PICK;
          end else if (cmd_evict) begin
            pend_q <= ent_valid & (NENT'(1) << cmd_idx);   // R4
            st_q   <= S_PICK;
          end
        end
        S_PICK: begin
          if (!pick_found) begin
            st_q <= S_IDLE;
          end else begin
            cur_idx          <= pick_idx;
            cur_kind         <= pick_kind;                  // R2
            pend_q[pick_idx] <= 1'b0;
            st_q             <= ent_dirty[pick_idx] ? S_LOCK_WAIT : S_DROP;
          end
        end
        S_LOCK_WAIT: begin
          if (lock_gnt) begin
            word_idx <= '0;
            st_q     <= S_RUN;
          end
        end
        S_RUN: begin
          word_idx <= word_idx + 1'b1;                      // R13
          if (word_idx == WW'(LANES - 1))
            st_q <= S_WB;
        end
        S_WB: begin
          if (wb_ready)
            st_q <= S_CLR;                                  // R11
        end
        S_CLR:  st_q <= S_PICK;                             // R5
        S_DROP: st_q <= S_PICK;                             // R6
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign fill     = (st_q == S_LOCK_WAIT) && lock_gnt;
  assign wr_en    = (st_q == S_RUN);
  assign lock_req = (st_q == S_LOCK_WAIT) || (st_q == S_RUN) ||
                    (st_q == S_WB) || (st_q == S_CLR);
  assign wb_valid = (st_q == S_WB);
  assign ent_clr  = (st_q == S_CLR) || (st_q == S_DROP);
  assign busy     = (st_q != S_IDLE);

endmodule

// File: rtl/merge_sequencer.sv
module merge_sequencer import merge_seq_pkg::*; #(
  parameter int NENT  = 8,
  parameter int LANES = 16,
  parameter int LW    = 32,
  parameter logic [LW-1:0] SAT_LIMIT = 'h0000_FFFF,
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int WW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int LINE = LANES * LW,
  localparam int TW   = 2,
  localparam int NSLOT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [TW-1:0]     cfg_slot,
  input  logic [1:0]        cfg_kind,
  input  logic              cmd_full,
  input  logic              cmd_evict,
  input  logic [IW-1:0]     cmd_idx,
  input  logic [NENT-1:0]   ent_valid,
  input  logic [NENT-1:0]   ent_dirty,
  input  logic [TW*NENT-1:0] ent_mtype,
  output logic [IW-1:0]     line_idx,
  input  logic [LINE-1:0]   sb_src_line,
  input  logic [LINE-1:0]   l1_upd_line,
  output logic              lock_req,
  input  logic              lock_gnt,
  input  logic [LINE-1:0]   mem_line,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [LINE-1:0]   wb_line,
  output logic              ent_clr,
  output logic              busy
);

  logic [IW-1:0] pick_idx;
  kern_e         pick_kind;
  kern_e         cur_kind;
  kern_e         cfg_kind_e;
  logic [WW-1:0] word_idx;
  logic          fill;
  logic          wr_en;
  logic [LW-1:0] rd_src;
  logic [LW-1:0] rd_upd;
  logic [LW-1:0] rd_mem;
  logic [LW-1:0] res_w;

  assign cfg_kind_e = kern_e'(cfg_kind);

  merge_ftable #(.NSLOT(NSLOT)) u_ftable (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_slot (cfg_slot),
    .wr_kind (cfg_kind_e),
    .rd_slot (ent_mtype[pick_idx*TW +: TW]),
    .rd_kind (pick_kind)
  );

  merge_seq_ctl #(.NENT(NENT), .LANES(LANES)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_full  (cmd_full),
    .cmd_evict (cmd_evict),
    .cmd_idx   (cmd_idx),
    .ent_valid (ent_valid),
    .ent_dirty (ent_dirty),
    .pick_idx  (pick_idx),
    .pick_kind (pick_kind),
    .cur_idx   (line_idx),
    .cur_kind  (cur_kind),
    .word_idx  (word_idx),
    .lock_gnt  (lock_gnt),
    .wb_ready  (wb_ready),
    .fill      (fill),
    .wr_en     (wr_en),
    .lock_req  (lock_req),
    .wb_valid  (wb_valid),
    .ent_clr   (ent_clr),
    .busy      (busy)
  );

  merge_regs #(.LANES(LANES), .LW(LW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (fill),
    .ld_src   (sb_src_line),
    .ld_upd   (l1_upd_line),
    .ld_mem   (mem_line),
    .word_idx (word_idx),
    .rd_src   (rd_src),
    .rd_upd   (rd_upd),
    .rd_mem   (rd_mem),
    .wr_en    (wr_en),
    .wr_data  (res_w),
    .mem_line (wb_line)
  );

  merge_kernel #(.LW(LW), .SAT_LIMIT(SAT_LIMIT)) u_kernel (
    .kind  (cur_kind),
    .src_w (rd_src),
    .upd_w (rd_upd),
    .mem_w (rd_mem),
    .res_w (res_w)
  );

endmodule

// File: rtl/merge_sequencer_chk.sv
module merge_sequencer_chk #(
  parameter int NENT  = 8,
  parameter int LANES = 16,
  parameter int LW    = 32,
  localparam int IW   = (NENT > 1) ? $clog2(NENT) : 1,
  localparam int LINE = LANES * LW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lock_req,
  input logic            lock_gnt,
  input logic            wb_valid,
  input logic            wb_ready,
  input logic [LINE-1:0] wb_line,
  input logic [IW-1:0]   line_idx,
  input logic            ent_clr,
  input logic            busy
);

  logic        held_q;
  logic [15:0] since_gnt_q;

  // Cycles elapsed since the edge that accepted the grant
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q      <= 1'b0;
      since_gnt_q <= '1;
    end else begin
      if (!lock_req)
        held_q <= 1'b0;
      else if (lock_gnt)
        held_q <= 1'b1;
      if (lock_req && lock_gnt && !held_q)
        since_gnt_q <= '0;
      else if (since_gnt_q != '1)
        since_gnt_q <= since_gnt_q + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy && !lock_req && !wb_valid && !ent_clr));

  assert_wb_under_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (lock_req && held_q));

  assert_release_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_req) |-> $past(ent_clr));

  assert_clean_no_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_clr && !lock_req) |-> $past(!lock_req));

  assert_wb_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line) && $stable(line_idx)));

  assert_word_walk_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_valid) |-> (since_gnt_q == 16'(LANES)));

endmodule

bind merge_sequencer merge_sequencer_chk #(.NENT(NENT), .LANES(LANES), .LW(LW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lock_req (lock_req),
  .lock_gnt (lock_gnt),
  .wb_valid (wb_valid),
  .wb_ready (wb_ready),
  .wb_line  (wb_line),
  .line_idx (line_idx),
  .ent_clr  (ent_clr),
  .busy     (busy)
);

// File: tb/merge_sequencer_test.sv
module merge_sequencer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NENT  = 8;
  localparam int LANES = 16;
  localparam int LINE  = LANES * 32;
  localparam logic [31:0] LIM = 32'h0000_FFFF;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we;
  logic [1:0] cfg_slot, cfg_kind;
  logic cmd_full, cmd_evict;
  logic [2:0] cmd_idx;
  logic [NENT-1:0] ent_valid, ent_dirty;
  logic [2*NENT-1:0] ent_mtype;
  logic [2:0] line_idx;
  logic [LINE-1:0] sb_src_line, l1_upd_line, mem_line, wb_line;
  logic lock_req, lock_gnt, wb_valid, wb_ready, ent_clr, busy;

  logic [LINE-1:0] src_arr [NENT];
  logic [LINE-1:0] upd_arr [NENT];
  logic [LINE-1:0] mem_model [NENT];
  logic [1:0]      mtype [NENT];
  int              tbl [4];

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit locked = 0, bp = 0, wb_done = 0, prev_wbv = 0, prev_rdy = 1;
  int gnt_cnt = 0, gnt_delay = 0, gnt_step = 0;
  logic [LINE-1:0] prev_line;
  int expq [$];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NENT; i++) ent_mtype[i*2 +: 2] = mtype[i];
  end
  assign sb_src_line = src_arr[line_idx];
  assign l1_upd_line = upd_arr[line_idx];

  merge_sequencer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_kind(cfg_kind),
    .cmd_full(cmd_full), .cmd_evict(cmd_evict), .cmd_idx(cmd_idx),
    .ent_valid(ent_valid), .ent_dirty(ent_dirty), .ent_mtype(ent_mtype),
    .line_idx(line_idx), .sb_src_line(sb_src_line), .l1_upd_line(l1_upd_line),
    .lock_req(lock_req), .lock_gnt(lock_gnt), .mem_line(mem_line),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_line(wb_line),
    .ent_clr(ent_clr), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [LINE-1:0] act, input logic [LINE-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  // Kernel meaning taken from the requirement text
  function automatic logic [31:0] kref(int k, logic [31:0] s, logic [31:0] u, logic [31:0] m);
    logic [31:0] sum;
    sum = m + (u - s);
    case (k)
      0: return sum;
      1: return (m >= LIM || sum > LIM) ? LIM : sum;
      2: return m | u;
      default: return (u < m) ? u : m;
    endcase
  endfunction

  function automatic string ktag(int k);
    case (k)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic fill_entry(input int e);
    for (int w = 0; w < LANES; w++) begin
      logic [31:0] s;
      s = rnd();
      src_arr[e][w*32 +: 32]   = s;
      upd_arr[e][w*32 +: 32]   = s + (rnd() & 32'h0000_3FFF);
      mem_model[e][w*32 +: 32] = rnd() & 32'h0000_FFFF;
    end
    mem_model[e][31:0] = LIM + 32'd3;   // lane at or above the saturation limit
  endtask

  task automatic step();
    logic [LINE-1:0] expl;
    int idx;
    @(negedge clk);
    cyc++;
    // Lock grant model: one grant per request after gnt_delay cycles
    lock_gnt = 1'b0;
    if (!lock_req) begin
      locked  = 0;
      gnt_cnt = 0;
    end else if (!locked) begin
      if (gnt_cnt >= gnt_delay) begin
        lock_gnt = 1'b1;
        mem_line = mem_model[line_idx];
        locked   = 1;
        gnt_step = cyc;
      end else begin
        gnt_cnt++;
      end
    end
    // Entry clear
    if (ent_clr) begin
      if (expq.size() == 0) begin
        chk(0, "R12", "unexpected entry clear", LINE'(line_idx), '0);
      end else begin
        idx = expq[0];
        chk(line_idx == 3'(idx), "R3", "clear order", LINE'(line_idx), LINE'(idx));
        if (ent_dirty[idx])
          chk(lock_req && wb_done, "R5", "dirty clear under lock after writeback",
              LINE'({lock_req, wb_done}), LINE'(2'b11));
        else
          chk(!lock_req && !locked, "R6", "clean clear without lock",
              LINE'(lock_req), '0);
        void'(expq.pop_front());
        wb_done = 0;
      end
    end
    // Writeback stream
    if (wb_valid) begin
      if (expq.size() == 0 || !ent_dirty[expq[0]]) begin
        chk(0, "R6", "unexpected writeback", LINE'(line_idx), '0);
      end else begin
        idx = expq[0];
        chk(locked && lock_req, "R5", "writeback only after grant", LINE'(locked), LINE'(1));
        chk(line_idx == 3'(idx), "R3", "writeback entry", LINE'(line_idx), LINE'(idx));
        if (!prev_wbv)
          chk(cyc - gnt_step == LANES + 1, "R13", "grant to writeback cycles",
              LINE'(cyc - gnt_step), LINE'(LANES + 1));
        if (prev_wbv && !prev_rdy)
          chk(wb_line == prev_line, "R11", "line held under back-pressure", wb_line, prev_line);
      end
    end
    wb_ready = bp ? ((cyc % 3) != 0) : 1'b1;
    if (wb_valid && wb_ready && expq.size() != 0 && ent_dirty[expq[0]]) begin
      int k;
      idx = expq[0];
      k = tbl[mtype[idx]];
      for (int w = 0; w < LANES; w++)
        expl[w*32 +: 32] = kref(k, src_arr[idx][w*32 +: 32], upd_arr[idx][w*32 +: 32],
                                mem_model[idx][w*32 +: 32]);
      chk(wb_line == expl, ktag(k), "merged line", wb_line, expl);
      mem_model[idx] = expl;
      wb_done = 1;
    end
    prev_wbv  = wb_valid;
    prev_rdy  = wb_ready;
    prev_line = wb_line;
  endtask

  task automatic program_slot(input int slot, input int kind);   // R2
    cfg_we = 1'b1; cfg_slot = 2'(slot); cfg_kind = 2'(kind);
    step();
    cfg_we = 1'b0;
    tbl[slot] = kind;
  endtask

  task automatic issue_full();
    if (!busy)
      for (int i = 0; i < NENT; i++) if (ent_valid[i]) expq.push_back(i);
    cmd_full = 1'b1;
    step();
    cmd_full = 1'b0;
  endtask

  task automatic issue_evict(input int e);
    if (!busy && ent_valid[e]) expq.push_back(e);
    cmd_evict = 1'b1; cmd_idx = 3'(e);
    step();
    cmd_evict = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    step();
    while (busy && n < 3000) begin step(); n++; end
    chk(expq.size() == 0, tag, "every expected entry visited", LINE'(expq.size()), '0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected idle");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_slot = 0; cfg_kind = 0; cmd_full = 0; cmd_evict = 0;
    cmd_idx = 0; ent_valid = 0; ent_dirty = 0; lock_gnt = 0; wb_ready = 1; mem_line = '0;
    prev_line = '0;
    for (int i = 0; i < 4; i++) tbl[i] = i;
    for (int i = 0; i < NENT; i++) begin fill_entry(i); mtype[i] = 2'(i % 4); end

    // R1: quiet in reset and just after
    repeat (3) begin
      step();
      chk(!busy && !lock_req && !wb_valid && !ent_clr, "R1", "outputs in reset",
          LINE'({busy, lock_req, wb_valid, ent_clr}), '0);
    end
    rst_n = 1'b1;
    step();
    chk(!busy && !lock_req && !wb_valid && !ent_clr, "R1", "outputs after reset",
        LINE'({busy, lock_req, wb_valid, ent_clr}), '0);

    // R3 with reset table (R2 identity), all kernels, all dirty
    ent_valid = 8'b0100_1111; ent_dirty = 8'hFF; gnt_delay = 0; bp = 0;
    issue_full();
    wait_idle("R3");

    // R2: rewrite slots, mixed clean/dirty (R6), back-pressure (R11), slow grant
    program_slot(0, 3);
    program_slot(3, 0);
    for (int i = 0; i < NENT; i++) fill_entry(i);
    ent_valid = 8'hFF; ent_dirty = 8'b1010_0101; gnt_delay = 3; bp = 1;
    issue_full();
    wait_idle("R2");

    // R4: single eviction, clean eviction, invalid eviction
    for (int i = 0; i < NENT; i++) fill_entry(i);
    ent_valid = 8'b0110_0010; ent_dirty = 8'b0010_0010; gnt_delay = 1; bp = 0;
    issue_evict(5);
    wait_idle("R4");
    issue_evict(6);
    wait_idle("R4");
    issue_evict(4);
    wait_idle("R4");

    // R12: commands while busy are dropped
    ent_valid = 8'b0000_0110; ent_dirty = 8'b0000_0110; gnt_delay = 2;
    issue_evict(2);
    step();
    issue_full();
    issue_evict(1);
    wait_idle("R12");

    // R8 focus: saturating kernel on every slot, back-pressure
    for (int s = 0; s < 4; s++) program_slot(s, 1);
    for (int i = 0; i < NENT; i++) fill_entry(i);
    ent_valid = 8'b1001_0011; ent_dirty = 8'hFF; bp = 1; gnt_delay = 0;
    issue_full();
    wait_idle("R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule